// File: doc/BRIEF.md
# Stereo Variable Delay Line with Selectable Feedback

This block is the delay-effect engine of a stereo audio path. Each channel writes its incoming samples into a circular on-chip memory. It reads each one back a run-time-programmable number of samples later. Before a sample is stored, a scaled feedback term is added to it. The feedback term comes from one of two places. In internal mode it is the block's own delayed output. In external mode it is a sample returned from processing outside the block, such as a frequency shifter. The delayed sample is presented on a tap output, so it can be sent to that outside processing and come back on the return inputs.

The block runs in a fast system clock domain and advances once per accepted sample strobe. Each strobe starts a three-phase sequence. The first phase captures the inputs and forms the read address. The second phase performs a synchronous memory read. The third phase writes the new sample and updates the tap. The buffer depth is `2**ADDR_W` samples per channel. The default is 1024, and `ADDR_W = 15` gives 32768. Strobes must be at least three clocks apart. A strobe that arrives while a sequence is in progress is ignored.

Top module: `stereo_delay_fx`

## Requirements
- R1: While `rst_ni` is low, both tap outputs are 0, the write pointer is 0 and the latched return samples are 0. The memory contents power up as 0.
- R2: The tap outputs change only on the second rising clock edge after the edge that accepts a strobe. A strobe is accepted only when no sequence is in progress.
- R3: For the n-th accepted strobe (counting from 0), the tap shows the sample written by strobe n-d, where d is the effective delay. If n-d is negative, the tap shows 0. The read address is the write pointer minus d, modulo the depth, and the write pointer advances by one per sample.
- R4: The effective delay is `delay_i` clamped to the range 1 to `2**ADDR_W - 1`. A value of 0 acts as 1, and any larger value acts as the maximum.
- R5: `delay_i` is sampled at the accepting strobe, so a new delay takes effect at the next strobe.
- R6: In internal mode (`fb_ext_i` = 0), the stored value is the input plus floor(tap_value * gain / 65536). Here tap_value is the delayed sample read for the same strobe and gain is `fb_gain_i`, read as an unsigned 16-bit fraction.
- R7: In external mode (`fb_ext_i` = 1), the return sample latched at strobe k is the one scaled and added to the input at strobe k+1. Before the first latch the return is 0.
- R8: The sum of input and scaled feedback saturates to the range -32768 to 32767 before it is stored.
- R9: A gain of 0 stores the input unchanged.
- R10: Left and right channels use the same delay, gain and mode, but their data paths do not affect each other.
- R11: Changes on the sample, return, delay, gain and mode inputs between strobes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| strobe_i | input | 1 | One-clock sample strobe |
| delay_i | input | 16 | Requested delay in samples, clamped |
| fb_gain_i | input | 16 | Unsigned feedback gain fraction |
| fb_ext_i | input | 1 | 1 selects external return as feedback source |
| in_l_i | input | 16 | Left input sample, signed |
| in_r_i | input | 16 | Right input sample, signed |
| ret_l_i | input | 16 | Left external return sample, signed |
| ret_r_i | input | 16 | Right external return sample, signed |
| tap_l_o | output | 16 | Left delayed sample |
| tap_r_o | output | 16 | Right delayed sample |

## Verification
The bench builds the block with `ADDR_W = 4`, which gives a 16-sample buffer. This lets a short run wrap the circular pointer many times and drive the delay to its upper clamp of 15 with settings such as 200. With that small depth, long runs at the maximum delay and feedback with gain near unity drive the stored values into saturation within a few dozen samples. Both feedback modes and live delay changes are compared against a queue-based model on every clock.

// File: rtl/dly_pkg.sv
package dly_pkg;
  localparam int SMP_W  = 16;
  localparam int GAIN_W = 16;

  typedef logic signed [SMP_W-1:0] smp_t;

  typedef enum logic [1:0] {PH_IDLE, PH_READ, PH_WRITE} phase_e;

  function automatic smp_t sat_add(input smp_t a, input smp_t b);
    logic signed [SMP_W:0] s;
    s = (SMP_W+1)'(a) + (SMP_W+1)'(b);
    if (s[SMP_W] != s[SMP_W-1])
      return s[SMP_W] ? {1'b1, {(SMP_W-1){1'b0}}} : {1'b0, {(SMP_W-1){1'b1}}};
    return s[SMP_W-1:0];
  endfunction
endpackage

// File: rtl/dly_mem.sv
module dly_mem
  import dly_pkg::*;
#(
  parameter int ADDR_W = 10,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] wa_i,
  input  smp_t              wd_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] ra_i,
  output smp_t              rd_o
);
  smp_t mem [DEPTH];

  // block memory init value
  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
  end

  always_ff @(posedge clk_i) begin
    if (we_i) mem[wa_i] <= wd_i;
    if (re_i) rd_o <= mem[ra_i];
  end
endmodule

// File: rtl/dly_fb.sv
module dly_fb
  import dly_pkg::*;
(
  input  smp_t              in_i,
  input  smp_t              dly_i,
  input  smp_t              ret_i,
  input  logic              ext_i,
  input  logic [GAIN_W-1:0] gain_i,
  output smp_t              wd_o
);
  localparam int PROD_W = SMP_W + GAIN_W + 1;

  smp_t                      fb_src;
  logic signed [PROD_W-1:0]  prod;
  smp_t                      fb_scaled;

  always_comb begin
    fb_src    = ext_i ? ret_i : dly_i;
    prod      = PROD_W'(fb_src) * PROD_W'($signed({1'b0, gain_i}));
    fb_scaled = prod[GAIN_W +: SMP_W];  // floor divide by 2**GAIN_W
    wd_o      = sat_add(in_i, fb_scaled);
  end
endmodule

// File: rtl/dly_ctrl.sv
module dly_ctrl
  import dly_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DLY_W  = 16,
  localparam int MAX_DLY = (1 << ADDR_W) - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              strobe_i,
  input  logic [DLY_W-1:0]  delay_i,
  output logic              accept_o,
  output logic              rd_en_o,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic [ADDR_W-1:0] wr_addr_o
);
  phase_e            phase_q;
  logic [DLY_W-1:0]  dly_c;

  assign accept_o = strobe_i && (phase_q == PH_IDLE);
  assign rd_en_o  = (phase_q == PH_READ);
  assign wr_en_o  = (phase_q == PH_WRITE);

  always_comb begin
    if (delay_i == '0)                     dly_c = DLY_W'(1);
    else if (delay_i > DLY_W'(MAX_DLY))    dly_c = DLY_W'(MAX_DLY);
    else                                   dly_c = delay_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q   <= PH_IDLE;
      rd_addr_o <= '0;
      wr_addr_o <= '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: if (strobe_i) begin
          phase_q   <= PH_READ;
          rd_addr_o <= wr_addr_o - dly_c[ADDR_W-1:0];
        end
        PH_READ:  phase_q <= PH_WRITE;
        PH_WRITE: begin
          phase_q   <= PH_IDLE;
          wr_addr_o <= wr_addr_o + 1'b1;
        end
        default:  phase_q <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/stereo_delay_fx.sv
module stereo_delay_fx
  import dly_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DLY_W  = 16,
  localparam int N_CH  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              strobe_i,
  input  logic [DLY_W-1:0]  delay_i,
  input  logic [GAIN_W-1:0] fb_gain_i,
  input  logic              fb_ext_i,
  input  logic [SMP_W-1:0]  in_l_i,
  input  logic [SMP_W-1:0]  in_r_i,
  input  logic [SMP_W-1:0]  ret_l_i,
  input  logic [SMP_W-1:0]  ret_r_i,
  output logic [SMP_W-1:0]  tap_l_o,
  output logic [SMP_W-1:0]  tap_r_o
);
  logic              accept, rd_en, wr_en;
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic [GAIN_W-1:0] gain_q;
  logic              ext_q;

  smp_t in_w  [N_CH];
  smp_t ret_w [N_CH];
  smp_t tap_q [N_CH];

  assign in_w[0]  = in_l_i;
  assign in_w[1]  = in_r_i;
  assign ret_w[0] = ret_l_i;
  assign ret_w[1] = ret_r_i;
  assign tap_l_o  = tap_q[0];
  assign tap_r_o  = tap_q[1];

  dly_ctrl #(.ADDR_W(ADDR_W), .DLY_W(DLY_W)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .strobe_i  (strobe_i),
    .delay_i   (delay_i),
    .accept_o  (accept),
    .rd_en_o   (rd_en),
    .wr_en_o   (wr_en),
    .rd_addr_o (rd_addr),
    .wr_addr_o (wr_addr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gain_q <= '0;
      ext_q  <= 1'b0;
    end else if (accept) begin
      gain_q <= fb_gain_i;
      ext_q  <= fb_ext_i;
    end
  end

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
    smp_t in_q, ret_q, ret_use, rd_data, wd;

    // return latched at strobe k feeds the write of strobe k+1
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        in_q      <= '0;
        ret_q     <= '0;
        ret_use   <= '0;
        tap_q[ch] <= '0;
      end else begin
        if (accept) begin
          in_q    <= in_w[ch];
          ret_use <= ret_q;
          ret_q   <= ret_w[ch];
        end
        if (wr_en) tap_q[ch] <= rd_data;
      end
    end

    dly_mem #(.ADDR_W(ADDR_W)) u_mem (
      .clk_i (clk_i),
      .we_i  (wr_en),
      .wa_i  (wr_addr),
      .wd_i  (wd),
      .re_i  (rd_en),
      .ra_i  (rd_addr),
      .rd_o  (rd_data)
    );

    dly_fb u_fb (
      .in_i   (in_q),
      .dly_i  (rd_data),
      .ret_i  (ret_use),
      .ext_i  (ext_q),
      .gain_i (gain_q),
      .wd_o   (wd)
    );
  end
endmodule

// File: rtl/dly_chk.sv
module dly_chk #(
  parameter int ADDR_W = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              strobe_i,
  input logic              rd_en_i,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] rd_addr_i,
  input logic [ADDR_W-1:0] wr_ptr_i,
  input logic [15:0]       tap_l_i,
  input logic [15:0]       tap_r_i
);
  // R1
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      reset_tap_zero_chk: assert (tap_l_i == '0 && tap_r_i == '0 && wr_ptr_i == '0);
    end
  end

  // R2
  tap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> ($stable(tap_l_i) && $stable(tap_r_i)));

  // R2
  read_after_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_en_i) |-> $past(strobe_i));

  // R3
  ptr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> wr_ptr_i == ADDR_W'($past(wr_ptr_i) + 1'b1));

  // R4
  dly_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |-> rd_addr_i != wr_ptr_i);

  // R11
  ptr_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(wr_ptr_i));
endmodule

bind stereo_delay_fx dly_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .strobe_i  (strobe_i),
  .rd_en_i   (rd_en),
  .wr_en_i   (wr_en),
  .rd_addr_i (rd_addr),
  .wr_ptr_i  (wr_addr),
  .tap_l_i   (tap_l_o),
  .tap_r_i   (tap_r_o)
);

// File: tb/stereo_delay_fx_tb_top.sv
module stereo_delay_fx_tb_top;
  localparam int ADDR_W  = 4;
  localparam int MAX_DLY = (1 << ADDR_W) - 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strobe = 1'b0;
  logic [15:0] delay = 16'd1;
  logic [15:0] gain = '0;
  logic        ext = 1'b0;
  logic [15:0] in_l = '0, in_r = '0, ret_l = '0, ret_r = '0;
  logic [15:0] tap_l, tap_r;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  bit mon_en = 1'b0;

  int wl[$];
  int wr[$];
  int n = 0;
  int ret_pl = 0, ret_pr = 0;
  int exp_l = 0, exp_r = 0;

  always #2.5 clk = ~clk;

  stereo_delay_fx #(.ADDR_W(ADDR_W)) dut_i (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .strobe_i  (strobe),
    .delay_i   (delay),
    .fb_gain_i (gain),
    .fb_ext_i  (ext),
    .in_l_i    (in_l),
    .in_r_i    (in_r),
    .ret_l_i   (ret_l),
    .ret_r_i   (ret_r),
    .tap_l_o   (tap_l),
    .tap_r_o   (tap_r)
  );

  task automatic check(string tag, int act, int expv);
    checks++;
    if (act != expv) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic int sat16(int v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic int scale(int v, int g);
    longint p;
    p = longint'(v) * longint'(g);
    return int'(p >>> 16);
  endfunction

  // R2: every clock, tap equals the model's current value
  always @(negedge clk) begin
    if (mon_en) begin
      check("R2 tap_l hold", int'($signed(tap_l)), exp_l);
      check("R2 tap_r hold", int'($signed(tap_r)), exp_r);
    end
  end

  task automatic step(string tag, int xl, int xr, int d, int g, bit e, int rl, int rr);
    int dc, yl, yr, fl, fr;
    @(negedge clk);
    in_l = 16'(xl); in_r = 16'(xr); delay = 16'(d); gain = 16'(g); ext = e;
    ret_l = 16'(rl); ret_r = 16'(rr); strobe = 1'b1;
    @(negedge clk);
    strobe = 1'b0;
    // R11: disturb inputs between strobes
    in_l = 16'h1234; in_r = 16'h8001; delay = 16'd9; gain = 16'hFFFF; ext = ~e;
    ret_l = 16'h7000; ret_r = 16'h9000;
    @(posedge clk);
    @(posedge clk);
    #1;
    dc = (d == 0) ? 1 : ((d > MAX_DLY) ? MAX_DLY : d);
    yl = (n - dc >= 0) ? wl[n - dc] : 0;
    yr = (n - dc >= 0) ? wr[n - dc] : 0;
    fl = scale(e ? ret_pl : yl, g);
    fr = scale(e ? ret_pr : yr, g);
    wl.push_back(sat16(xl + fl));
    wr.push_back(sat16(xr + fr));
    n++;
    ret_pl = rl; ret_pr = rr;
    exp_l = yl; exp_r = yr;
    @(negedge clk);
    check(tag, int'($signed(tap_l)), exp_l);
    check(tag, int'($signed(tap_r)), exp_r);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 tap_l reset", int'(tap_l), 0);
    check("R1 tap_r reset", int'(tap_r), 0);
    rst_n = 1'b1;
    mon_en = 1'b1;
    // R3, R9, R10: plain delay 3, no feedback, different L/R data
    for (int i = 0; i < 20; i++) step("R3 R9 R10 delay 3", 100 * i + 1, -37 * i, 3, 0, 0, 0, 0);
    // R5: delay change applies at the next strobe
    for (int i = 0; i < 6; i++) step("R5 delay 7", 500 + i, -500 - i, 7, 0, 0, 0, 0);
    // R4: clamp low and high, pointer wrap
    for (int i = 0; i < 5; i++) step("R4 delay 0 acts as 1", 2000 + i, 3000 - i, 0, 0, 0, 0, 0);
    for (int i = 0; i < 40; i++) step("R4 delay 200 acts as max", i * 11 - 200, i * 7, 200, 0, 0, 0, 0);
    // R6: internal feedback, half gain, impulse then silence
    step("R6 impulse", 10000, -10000, 2, 16'h8000, 0, 0, 0);
    for (int i = 0; i < 16; i++) step("R6 internal feedback", 0, 0, 2, 16'h8000, 0, 0, 0);
    // R8: near-unity gain with loud input drives saturation
    for (int i = 0; i < 20; i++) step("R8 saturate", 30000, -30000, 1, 16'hFFFF, 0, 0, 0);
    // R7: external return used one strobe later
    for (int i = 0; i < 20; i++)
      step("R7 external feedback", 50 * i, -20 * i, 4, 16'hC000, 1, 1000 * i - 9000, 12000 - 700 * i);
    for (int i = 0; i < 8; i++)
      step("R7 R8 external saturate", 32000, -32000, 5, 16'hFFFF, 1, 32767, -32768);
    mon_en = 1'b0;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule